// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in an out-of-order integer core. The front end presents one instruction per cycle; the buffer accepts it only when it has a free slot and the execution queue the instruction is bound for (the arithmetic reservation station or the load/store queue) can also take it. Each accepted instruction receives a tag equal to its slot number and is handed to its queue one cycle later. Execution units return (tag, value) pairs on a shared result bus in any order, and the buffer marks the matching slot complete.

Every cycle the buffer looks at up to WIDTH slots starting from the oldest one and retires the completed entries it finds in order, stopping at the first one that is not complete. Ordinary entries write their value into the architectural register file; branch entries write nothing but compare their resolved direction with the prediction made at dispatch. A wrong prediction throws away every younger entry, sends the corrected program counter to the front end and raises one flush pulse to the queues and the front end. An external flush request empties the buffer in the same way without a redirect. A capacity or retire width below one stops elaboration.

Top module: `rob_core`

## Requirements
- R1: `disp_ready` is low while DEPTH entries are outstanding, or while the selected queue reports full (`rs_full` when `disp_is_mem`=0, `lsq_full` when `disp_is_mem`=1); out of reset it is high with every output pulse low.
- R2: A dispatch presented while `disp_ready` is low raises `disp_err` in that cycle, is not stored, consumes no tag and produces no queue push.
- R3: Accepted instructions receive tags equal to their slot number, 0, 1, 2, … wrapping modulo DEPTH, starting at 0 after reset and after any flush; no more than DEPTH tags are ever outstanding.
- R4: An instruction accepted at a clock edge appears for exactly one cycle after that edge on `rs_push` (`disp_is_mem`=0) or `lsq_push` (`disp_is_mem`=1), with its tag on `fwd_tag` and its destination on `fwd_rd`.
- R5: A result marks the outstanding entry whose slot equals `res_tag` complete, whatever the order; a result whose tag names no outstanding entry changes nothing.
- R6: While the oldest entry is incomplete, no register-file write port is active, however many younger entries are complete.
- R7: In each cycle up to WIDTH completed entries are retired from the oldest onward, lane 0 carrying the oldest; retirement stops at the first incomplete entry. The write ports are active in the cycle after the edge on which the last needed result was captured.
- R8: Each retirement frees its slot, so after a full drain DEPTH further instructions are accepted.
- R9: A branch entry never writes the register file; bit 0 of its result is the taken direction. If that differs from `disp_pred_taken`, no younger entry retires, the buffer empties, and in the following cycle `redirect_valid` and `flush_out` are high for one cycle with `redirect_pc` equal to the branch's `disp_fix_pc`. A correctly predicted branch retires with no flush.
- R10: `flush_in` empties the buffer (ready again, tags restart at 0) and gives one `flush_out` cycle after the edge, with `redirect_valid` low; a result or retirement in the same cycle as `flush_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | Dispatch request |
| disp_is_mem | input | 1 | 1 = memory op for the load/store queue, 0 = arithmetic op |
| disp_is_branch | input | 1 | Instruction is a conditional branch |
| disp_pred_taken | input | 1 | Predicted direction of the branch |
| disp_rd | input | RW | Destination register index |
| disp_fix_pc | input | PCW | PC to fetch from if the branch prediction is wrong |
| disp_ready | output | 1 | Request would be accepted |
| disp_err | output | 1 | Request made while not ready; instruction dropped |
| disp_tag | output | AW | Tag the current request receives |
| rs_full | input | 1 | Reservation station cannot take more |
| lsq_full | input | 1 | Load/store queue cannot take more |
| rs_push | output | 1 | Instruction handed to the reservation station |
| lsq_push | output | 1 | Instruction handed to the load/store queue |
| fwd_tag | output | AW | Tag of the handed-over instruction |
| fwd_rd | output | RW | Destination of the handed-over instruction |
| res_valid | input | 1 | Result bus valid |
| res_tag | input | AW | Tag of the result |
| res_value | input | XLEN | Result value (bit 0 = taken for branches) |
| flush_in | input | 1 | External flush request |
| rf_we | output | WIDTH | Register-file write enable per retire lane |
| rf_waddr | output | WIDTH*RW | Write address per lane, lane k at bits k*RW |
| rf_wdata | output | WIDTH*XLEN | Write data per lane, lane k at bits k*XLEN |
| redirect_valid | output | 1 | Corrected PC is valid |
| redirect_pc | output | PCW | Corrected PC |
| flush_out | output | 1 | Flush pulse to both queues and the front end |

## Verification
The embedded properties rely on execution units only returning tags that are currently outstanding and returning each tag at most once, and on the front end holding `disp_is_mem` constant with `disp_valid` within a cycle. The stimulus respects this by keeping its own model of outstanding tags: every result it sends names a tag it was given, except the deliberate stale results sent to an empty buffer, which the design must ignore. The scoreboard expects register writes only for non-branch entries it knows will survive, so any write from a discarded or blocked entry shows up as a mismatch.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

  typedef enum logic {
    UNIT_ALU = 1'b0,
    UNIT_MEM = 1'b1
  } unit_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [CW-1:0] n_ret,
  input  logic          clear,
  output logic [AW-1:0] head_idx,
  output logic [AW-1:0] tail_idx,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);

  logic [AW:0] head_q, tail_q, head_n, tail_n;

  function automatic logic [AW:0] advance(input logic [AW:0] p, input int amt);
    int   s;
    logic w;
    s = int'(p[AW-1:0]) + amt;
    w = p[AW];
    if (s >= DEPTH) begin
      s = s - DEPTH;
      w = ~w;
    end
    return {w, AW'(s)};
  endfunction

  always_comb begin
    int hi, ti, oc;
    hi = int'(head_q[AW-1:0]);
    ti = int'(tail_q[AW-1:0]);
    oc = (head_q[AW] == tail_q[AW]) ? (ti - hi) : (DEPTH - hi + ti);
    occ = CW'(oc);
  end

  assign head_idx = head_q[AW-1:0];
  assign tail_idx = tail_q[AW-1:0];
  assign full     = (occ == CW'(DEPTH));
  assign empty    = (occ == '0);

  always_comb begin
    if (clear) begin
      head_n = '0;
      tail_n = '0;
    end else begin
      head_n = advance(head_q, int'(n_ret));
      tail_n = alloc ? advance(tail_q, 1) : tail_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_no_overalloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !clear) |-> !full);

endmodule

// File: rtl/rob_commit_sel.sv
`timescale 1ns/1ps
module rob_commit_sel #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int LANES = 2,
  parameter int CW    = 4
) (
  input  logic [AW-1:0]       head_idx,
  input  logic [DEPTH-1:0]    valid_v,
  input  logic [DEPTH-1:0]    done_v,
  input  logic [DEPTH-1:0]    branch_v,
  input  logic [DEPTH-1:0]    pred_v,
  input  logic [DEPTH-1:0]    taken_v,
  input  logic                block,
  output logic [LANES-1:0]    lane_ret,
  output logic [LANES-1:0]    lane_we,
  output logic [LANES*AW-1:0] lane_idx,
  output logic [CW-1:0]       n_ret,
  output logic                mis,
  output logic [AW-1:0]       mis_idx
);

  always_comb begin
    logic          stop;
    int            cnt;
    logic [AW-1:0] ix;
    stop     = block;
    cnt      = 0;
    lane_ret = '0;
    lane_we  = '0;
    lane_idx = '0;
    mis      = 1'b0;
    mis_idx  = '0;
    for (int k = 0; k < LANES; k++) begin
      ix = AW'((int'(head_idx) + k) % DEPTH);
      lane_idx[k*AW +: AW] = ix;
      if (!stop && valid_v[ix] && done_v[ix]) begin
        lane_ret[k] = 1'b1;
        cnt = cnt + 1;
        if (branch_v[ix]) begin
          if (taken_v[ix] != pred_v[ix]) begin
            mis     = 1'b1;
            mis_idx = ix;
            stop    = 1'b1;
          end
        end else begin
          lane_we[k] = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
    n_ret = CW'(cnt);
  end

endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 2,
  parameter int XLEN  = 16,
  parameter int NREG  = 8,
  parameter int PCW   = 16,
  localparam int AW    = idx_bits(DEPTH),
  localparam int RW    = idx_bits(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  input  logic                  disp_is_mem,
  input  logic                  disp_is_branch,
  input  logic                  disp_pred_taken,
  input  logic [RW-1:0]         disp_rd,
  input  logic [PCW-1:0]        disp_fix_pc,
  output logic                  disp_ready,
  output logic                  disp_err,
  output logic [AW-1:0]         disp_tag,
  input  logic                  rs_full,
  input  logic                  lsq_full,
  output logic                  rs_push,
  output logic                  lsq_push,
  output logic [AW-1:0]         fwd_tag,
  output logic [RW-1:0]         fwd_rd,
  input  logic                  res_valid,
  input  logic [AW-1:0]         res_tag,
  input  logic [XLEN-1:0]       res_value,
  input  logic                  flush_in,
  output logic [WIDTH-1:0]      rf_we,
  output logic [WIDTH*RW-1:0]   rf_waddr,
  output logic [WIDTH*XLEN-1:0] rf_wdata,
  output logic                  redirect_valid,
  output logic [PCW-1:0]        redirect_pc,
  output logic                  flush_out
);

  localparam int LANES = (WIDTH < DEPTH) ? WIDTH : DEPTH;
  localparam int CW    = $clog2(DEPTH + 1);

  if (DEPTH < 1) begin : g_bad_depth
    $error("rob_core: DEPTH must be at least 1");
  end
  if (WIDTH < 1) begin : g_bad_width
    $error("rob_core: WIDTH must be at least 1");
  end

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // entry state
  logic [DEPTH-1:0] v_q, d_q, br_q, pt_q;
  logic [DEPTH-1:0] v_n, d_n, br_n, pt_n;
  logic [RW-1:0]    rd_q  [DEPTH];
  logic [XLEN-1:0]  val_q [DEPTH];
  logic [PCW-1:0]   pc_q  [DEPTH];
  logic [DEPTH-1:0] taken_v, res_hit;

  logic [AW-1:0]       head_idx, tail_idx, mis_idx;
  logic [CW-1:0]       occ, n_ret;
  logic                full, empty, mis, flush_any, alloc, unit_full;
  logic [LANES-1:0]    lane_ret, lane_we;
  logic [LANES*AW-1:0] lane_idx;
  unit_e               unit_sel;

  logic                rs_push_q, lsq_push_q, flush_q, redir_q;
  logic [AW-1:0]       fwd_tag_q;
  logic [RW-1:0]       fwd_rd_q;
  logic [PCW-1:0]      redir_pc_q;

  // dispatch gating
  assign unit_sel   = disp_is_mem ? UNIT_MEM : UNIT_ALU;
  assign unit_full  = (unit_sel == UNIT_MEM) ? lsq_full : rs_full;
  assign disp_ready = !full && !unit_full;
  assign disp_err   = disp_valid && !disp_ready;
  assign disp_tag   = tail_idx;
  assign flush_any  = flush_in || mis;
  assign alloc      = disp_valid && disp_ready && !flush_any;

  rob_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_i),
    .alloc    (alloc),
    .n_ret    (n_ret),
    .clear    (flush_any),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .occ      (occ),
    .full     (full),
    .empty    (empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign taken_v[i] = val_q[i][0];
    assign res_hit[i] = res_valid && !flush_any && v_q[i] && (res_tag == AW'(i));
  end

  rob_commit_sel #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .CW(CW)) u_sel (
    .head_idx (head_idx),
    .valid_v  (v_q),
    .done_v   (d_q),
    .branch_v (br_q),
    .pred_v   (pt_q),
    .taken_v  (taken_v),
    .block    (flush_in),
    .lane_ret (lane_ret),
    .lane_we  (lane_we),
    .lane_idx (lane_idx),
    .n_ret    (n_ret),
    .mis      (mis),
    .mis_idx  (mis_idx)
  );

  // next state of the entry flags
  always_comb begin
    v_n  = v_q;
    d_n  = d_q;
    br_n = br_q;
    pt_n = pt_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (res_hit[i]) d_n[i] = 1'b1;
    end
    for (int k = 0; k < LANES; k++) begin
      if (lane_ret[k]) begin
        v_n[lane_idx[k*AW +: AW]] = 1'b0;
        d_n[lane_idx[k*AW +: AW]] = 1'b0;
      end
    end
    if (alloc) begin
      v_n[tail_idx]  = 1'b1;
      d_n[tail_idx]  = 1'b0;
      br_n[tail_idx] = disp_is_branch;
      pt_n[tail_idx] = disp_pred_taken;
    end
    if (flush_any) begin
      v_n = '0;
      d_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v_q        <= '0;
      d_q        <= '0;
      br_q       <= '0;
      pt_q       <= '0;
      rs_push_q  <= 1'b0;
      lsq_push_q <= 1'b0;
      flush_q    <= 1'b0;
      redir_q    <= 1'b0;
    end else begin
      v_q        <= v_n;
      d_q        <= d_n;
      br_q       <= br_n;
      pt_q       <= pt_n;
      rs_push_q  <= alloc && !disp_is_mem;
      lsq_push_q <= alloc && disp_is_mem;
      flush_q    <= flush_any;
      redir_q    <= mis;
    end
  end

  // payload registers, enabled writes only
  always_ff @(posedge clk) begin
    if (alloc) begin
      rd_q[tail_idx] <= disp_rd;
      pc_q[tail_idx] <= disp_fix_pc;
      fwd_tag_q      <= tail_idx;
      fwd_rd_q       <= disp_rd;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (res_hit[i]) val_q[i] <= res_value;
    end
    if (mis) redir_pc_q <= pc_q[mis_idx];
  end

  assign rs_push        = rs_push_q;
  assign lsq_push       = lsq_push_q;
  assign fwd_tag        = fwd_tag_q;
  assign fwd_rd         = fwd_rd_q;
  assign flush_out      = flush_q;
  assign redirect_valid = redir_q;
  assign redirect_pc    = redir_pc_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_lane
    if (k < LANES) begin : g_on
      assign rf_we[k]               = lane_we[k];
      assign rf_waddr[k*RW +: RW]   = rd_q[lane_idx[k*AW +: AW]];
      assign rf_wdata[k*XLEN +: XLEN] = val_q[lane_idx[k*AW +: AW]];
    end else begin : g_off
      assign rf_we[k]               = 1'b0;
      assign rf_waddr[k*RW +: RW]   = '0;
      assign rf_wdata[k*XLEN +: XLEN] = '0;
    end
  end

  assert_err_drops_R2: assert property (@(posedge clk) disable iff (!rst_i)
    disp_err |=> !(rs_push || lsq_push));

  assert_push_follows_R4: assert property (@(posedge clk) disable iff (!rst_i)
    rs_push |-> $past(disp_valid && disp_ready && !disp_is_mem));

  assert_head_blocks_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (rf_we != '0) |-> (v_q[head_idx] && d_q[head_idx]));

  assert_redirect_flush_R9: assert property (@(posedge clk) disable iff (!rst_i)
    redirect_valid |-> flush_out);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_i)
    flush_out |-> (empty || $past(alloc)) );

endmodule

// File: tb/rob_core_bench.sv
`timescale 1ns/1ps
module rob_core_bench;

  localparam int DEPTH = 4;
  localparam int WIDTH = 2;
  localparam int XLEN  = 16;
  localparam int NREG  = 8;
  localparam int PCW   = 16;
  localparam int AW    = 2;
  localparam int RW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic disp_valid, disp_is_mem, disp_is_branch, disp_pred_taken;
  logic [RW-1:0] disp_rd;
  logic [PCW-1:0] disp_fix_pc;
  logic disp_ready, disp_err;
  logic [AW-1:0] disp_tag;
  logic rs_full, lsq_full, rs_push, lsq_push;
  logic [AW-1:0] fwd_tag;
  logic [RW-1:0] fwd_rd;
  logic res_valid;
  logic [AW-1:0] res_tag;
  logic [XLEN-1:0] res_value;
  logic flush_in;
  logic [WIDTH-1:0] rf_we;
  logic [WIDTH*RW-1:0] rf_waddr;
  logic [WIDTH*XLEN-1:0] rf_wdata;
  logic redirect_valid, flush_out;
  logic [PCW-1:0] redirect_pc;

  rob_core #(.DEPTH(DEPTH), .WIDTH(WIDTH), .XLEN(XLEN), .NREG(NREG), .PCW(PCW)) u_rob_core (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_is_mem(disp_is_mem), .disp_is_branch(disp_is_branch),
    .disp_pred_taken(disp_pred_taken), .disp_rd(disp_rd), .disp_fix_pc(disp_fix_pc),
    .disp_ready(disp_ready), .disp_err(disp_err), .disp_tag(disp_tag),
    .rs_full(rs_full), .lsq_full(lsq_full), .rs_push(rs_push), .lsq_push(lsq_push),
    .fwd_tag(fwd_tag), .fwd_rd(fwd_rd),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .flush_in(flush_in),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush_out(flush_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct { logic [RW-1:0] rd; logic [XLEN-1:0] v; } exp_t;
  exp_t expq[$];
  exp_t cur;
  int nchk = 0, nfail = 0, commit_seen = 0;
  bit run = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pops expected commits in lane order
  always @(negedge clk) begin
    if (run) begin
      for (int k = 0; k < WIDTH; k++) begin
        if (rf_we[k]) begin
          commit_seen++;
          if (expq.size() == 0) begin
            chk(1'b0, "R6 unexpected register write", int'(rf_wdata[k*XLEN +: XLEN]), 0);
          end else begin
            cur = expq.pop_front();
            chk(rf_waddr[k*RW +: RW] == cur.rd && rf_wdata[k*XLEN +: XLEN] == cur.v,
                "R7 commit order/data", int'(rf_wdata[k*XLEN +: XLEN]), int'(cur.v));
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic disp(input bit mem, input bit br, input bit pt, input logic [RW-1:0] rd,
                      input logic [PCW-1:0] pc, input bit expect_wr, input logic [XLEN-1:0] v,
                      input int exp_tag);
    exp_t e;
    disp_valid = 1'b1; disp_is_mem = mem; disp_is_branch = br; disp_pred_taken = pt;
    disp_rd = rd; disp_fix_pc = pc;
    #1;
    chk(disp_ready == 1'b1, "R8 ready before dispatch", int'(disp_ready), 1);
    chk(disp_tag == AW'(exp_tag), "R3 tag", int'(disp_tag), exp_tag);
    if (expect_wr && !br) begin e.rd = rd; e.v = v; expq.push_back(e); end
    @(negedge clk);
    chk((mem ? lsq_push : rs_push) == 1'b1 && (mem ? rs_push : lsq_push) == 1'b0,
        "R4 push to queue", int'({rs_push, lsq_push}), mem ? 1 : 2);
    chk(fwd_tag == AW'(exp_tag) && fwd_rd == rd, "R4 forwarded tag/rd", int'(fwd_tag), exp_tag);
    #1; disp_valid = 1'b0; #1;
  endtask

  task automatic result(input int tag, input logic [XLEN-1:0] v);
    res_valid = 1'b1; res_tag = AW'(tag); res_value = v;
    @(negedge clk); #1; res_valid = 1'b0; #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seen;
    rst_n = 1'b0; disp_valid = 0; disp_is_mem = 0; disp_is_branch = 0; disp_pred_taken = 0;
    disp_rd = '0; disp_fix_pc = '0; rs_full = 0; lsq_full = 0; res_valid = 0; res_tag = '0;
    res_value = '0; flush_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    run = 1'b1;

    // R1 reset state
    chk(disp_ready && !rs_push && !lsq_push && rf_we == 0 && !flush_out && !redirect_valid,
        "R1 reset state", int'(disp_ready), 1);
    chk(disp_tag == 0, "R3 first tag", int'(disp_tag), 0);
    // R1 downstream full
    rs_full = 1; disp_is_mem = 0; #1;
    chk(!disp_ready, "R1 rs_full blocks alu", int'(disp_ready), 0);
    disp_is_mem = 1; #1;
    chk(disp_ready, "R1 rs_full leaves mem", int'(disp_ready), 1);
    rs_full = 0; lsq_full = 1; #1;
    chk(!disp_ready, "R1 lsq_full blocks mem", int'(disp_ready), 0);
    lsq_full = 0; disp_is_mem = 0; #1;

    // fill: tags 0..3
    disp(0, 0, 0, 3'd1, 16'h0, 1, 16'h0011, 0);
    disp(0, 0, 0, 3'd2, 16'h0, 1, 16'h0022, 1);
    disp(1, 0, 0, 3'd3, 16'h0, 1, 16'h0033, 2);
    disp(0, 0, 0, 3'd4, 16'h0, 1, 16'h0044, 3);
    #1;
    chk(!disp_ready, "R1 full after DEPTH", int'(disp_ready), 0);
    // R2 dispatch while full
    disp_valid = 1; disp_rd = 3'd5; #1;
    chk(disp_err, "R2 error flag", int'(disp_err), 1);
    @(negedge clk);
    chk(!rs_push && !lsq_push, "R2 no push", int'({rs_push, lsq_push}), 0);
    #1; disp_valid = 0; #1;

    // R6 results out of order, head last
    result(3, 16'h0044); result(2, 16'h0033); result(1, 16'h0022);
    idle(1);
    chk(commit_seen == 0, "R6 head blocks commit", commit_seen, 0);
    result(0, 16'h0011);
    chk(rf_we == 2'b11, "R7 two lanes first", int'(rf_we), 3);
    idle(1);
    chk(rf_we == 2'b11, "R7 two lanes second", int'(rf_we), 3);
    idle(1);
    chk(rf_we == 2'b00 && commit_seen == 4, "R7 drained", commit_seen, 4);
    // R5 stale result
    result(1, 16'h0BAD);
    idle(2);
    chk(commit_seen == 4, "R5 stale result ignored", commit_seen, 4);

    // R8 refill after drain
    disp(0, 0, 0, 3'd5, 16'h0, 1, 16'h0055, 0);
    disp(0, 0, 0, 3'd6, 16'h0, 1, 16'h0066, 1);
    disp(1, 0, 0, 3'd7, 16'h0, 1, 16'h0077, 2);
    disp(0, 0, 0, 3'd0, 16'h0, 1, 16'h0008, 3);
    result(0, 16'h0055);
    chk(rf_we == 2'b01, "R7 single lane", int'(rf_we), 1);
    result(2, 16'h0077);
    chk(rf_we == 2'b00, "R7 stop at incomplete", int'(rf_we), 0);
    result(3, 16'h0008);
    chk(rf_we == 2'b00, "R7 still stopped", int'(rf_we), 0);
    result(1, 16'h0066);
    chk(rf_we == 2'b11, "R7 resume pair", int'(rf_we), 3);
    idle(1);
    chk(rf_we == 2'b01, "R7 last one", int'(rf_we), 1);
    idle(1);

    // R9 correct prediction
    disp(0, 1, 0, 3'd0, 16'h0200, 0, 16'h0, 0);
    disp(0, 0, 0, 3'd1, 16'h0, 1, 16'h0099, 1);
    result(0, 16'h0000);
    chk(rf_we == 2'b00, "R9 branch does not write", int'(rf_we), 0);
    result(1, 16'h0099);
    chk(rf_we == 2'b01, "R9 younger commits after good branch", int'(rf_we), 1);
    idle(1);
    chk(!redirect_valid && !flush_out, "R9 no flush on correct prediction", int'(flush_out), 0);

    // R9 misprediction
    disp(0, 1, 1, 3'd0, 16'h0123, 0, 16'h0, 2);
    disp(0, 0, 0, 3'd2, 16'h0, 0, 16'h0, 3);
    disp(1, 0, 0, 3'd3, 16'h0, 0, 16'h0, 0);
    seen = commit_seen;
    result(3, 16'h0005); result(0, 16'h0006);
    chk(commit_seen == seen, "R6 blocked behind branch", commit_seen, seen);
    result(2, 16'h0000);
    chk(rf_we == 2'b00 && !redirect_valid, "R9 no younger commit", int'(rf_we), 0);
    idle(1);
    chk(redirect_valid && flush_out, "R9 redirect and flush", int'({redirect_valid, flush_out}), 3);
    chk(redirect_pc == 16'h0123, "R9 redirect pc", int'(redirect_pc), 16'h0123);
    chk(disp_ready, "R9 buffer emptied", int'(disp_ready), 1);
    idle(1);
    chk(!flush_out && !redirect_valid, "R9 single pulse", int'(flush_out), 0);
    idle(2);
    chk(commit_seen == seen, "R9 discarded entries never write", commit_seen, seen);

    // R10 external flush with concurrent result
    disp(0, 0, 0, 3'd4, 16'h0, 0, 16'h0, 0);
    disp(0, 0, 0, 3'd5, 16'h0, 0, 16'h0, 1);
    flush_in = 1; res_valid = 1; res_tag = 0; res_value = 16'h0077;
    @(negedge clk); #1; flush_in = 0; res_valid = 0; #1;
    chk(flush_out && !redirect_valid, "R10 flush pulse without redirect",
        int'({flush_out, redirect_valid}), 2);
    chk(disp_ready && disp_tag == 0, "R10 empty and tag restart", int'(disp_tag), 0);
    idle(1);
    chk(!flush_out, "R10 one flush cycle", int'(flush_out), 0);
    result(0, 16'h0077);
    idle(2);
    chk(commit_seen == seen, "R10 flushed entry gone", commit_seen, seen);
    disp(0, 0, 0, 3'd6, 16'h0, 1, 16'h00AB, 0);
    result(0, 16'h00AB);
    chk(rf_we == 2'b01, "R10 works after flush", int'(rf_we), 1);
    idle(2);

    chk(expq.size() == 0, "R7 all expected commits seen", expq.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule